// File: doc/BRIEF.md
# Cascadable Up/Down Binary Counter

This block is a synchronous binary counter built from identical narrow stages (four bits each by default) that are chained into one wider counter. On every rising clock edge it either clears, takes a parallel preset value, steps by one in the selected direction, or keeps its value. Counting wraps around the full range in both directions.

Each stage has two active-low count enables. The first is shared by every stage. The second is a carry enable that is passed forward into the stage's active-low terminal-count output. That output is low when the carry enable is active and the stage sits at the end of its range: all ones when counting up, all zeros when counting down. Inside the chain, each stage's terminal-count output is the carry enable of the stage above it. The clock, direction, load and shared enable go to every stage. The terminal count is decoded without a register, so the chain looks ahead across all stages within one clock period.

A synchronous active-high reset is provided for start-up. It overrides every other control.

Top module: `udc_cascade`

## Requirements
- R1: When `rst` is high at a rising clock edge, the whole count becomes zero on that edge, whatever the other inputs are.
- R2: When `rst` is low and `load_n` is low at an edge, `q` takes the value of `din` on that edge, whatever the levels of `cnt_en_n` and `carry_en_n`.
- R3: When `rst` and `load_n` are high and either `cnt_en_n` or `carry_en_n` is high at an edge, `q` keeps its value.
- R4: When `rst` and `load_n` are high, both enables are low and `up` is 1, `q` increments by one modulo 2^(STAGE_W*NSTAGE). All-ones becomes zero.
- R5: Under the same conditions with `up` at 0, `q` decrements by one modulo 2^(STAGE_W*NSTAGE). Zero becomes all ones.
- R6: `tc_n` is 0 exactly when `carry_en_n` is 0 and the whole count is at its terminal value: all ones if `up` is 1, all zeros if `up` is 0. It follows changes on `carry_en_n`, `up` and `q` combinationally, without waiting for a clock edge.
- R7: Stage k (k ≥ 1) takes the terminal-count output of stage k-1 as its carry enable. Stage 0 takes `carry_en_n`. As a result the chain steps as one wide counter. Bits [STAGE_W*(k+1)-1 : STAGE_W*k] of `q` and `din` belong to stage k.
- R8: For a single stage, loading 12 and then counting up gives 13, 14, 15, 0, 1, 2. `tc_n` is low only while the count is 15 with both enables low. With `cnt_en_n` high the count then stays at 2.
- R9: The next state uses the value of `up` present at the clock edge. Earlier changes of `up` within the same cycle have no effect on it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state updates on the rising edge |
| rst | input | 1 | Synchronous clear, active high, highest priority |
| load_n | input | 1 | Parallel preset enable, active low |
| up | input | 1 | Direction: 1 counts up, 0 counts down |
| cnt_en_n | input | 1 | Count enable shared by all stages, active low |
| carry_en_n | input | 1 | Carry enable into stage 0, active low, forwarded to `tc_n` |
| din | input | STAGE_W*NSTAGE | Preset value |
| q | output | STAGE_W*NSTAGE | Current count |
| tc_n | output | 1 | Terminal count of the last stage, active low |

## Verification
The bench builds two copies of the block. The first uses STAGE_W=4 and NSTAGE=3, a 12-bit chain, so that carries and borrows cross stage boundaries and the count wraps at 0xFFF and 0x000. That copy is checked against an integer model under random control mixes, and the direction is flipped inside a cycle. The second uses NSTAGE=1 to replay the twelve-to-two preset-and-count sequence on a single stage, where the 4-bit terminal value is reached within a few edges.

// File: rtl/udc_pkg.sv
package udc_pkg;

    // Operation a stage performs on the next rising edge.
    typedef enum logic [2:0] {
        OP_HOLD  = 3'd0,
        OP_CLEAR = 3'd1,
        OP_LOAD  = 3'd2,
        OP_INC   = 3'd3,
        OP_DEC   = 3'd4
    } op_e;

endpackage

// File: rtl/udc_mode_sel.sv
module udc_mode_sel
    import udc_pkg::*;
(
    input  logic rst,
    input  logic load_n,
    input  logic up,
    input  logic cnt_en_n,
    input  logic carry_en_n,
    output op_e  op
);

    logic both_en;

    always_comb begin
        both_en = ~cnt_en_n & ~carry_en_n;
        if (rst) begin
            op = OP_CLEAR;
        end else if (!load_n) begin
            op = OP_LOAD;
        end else if (both_en) begin
            op = up ? OP_INC : OP_DEC;
        end else begin
            op = OP_HOLD;
        end
    end

endmodule

// File: rtl/udc_tc_decode.sv
module udc_tc_decode #(
    parameter int W = 4
) (
    input  logic [W-1:0] cnt,
    input  logic         up,
    input  logic         carry_en_n,
    output logic         tc_n
);

    logic at_top;
    logic at_bottom;
    logic at_end;

    always_comb begin
        at_top    = &cnt;
        at_bottom = ~|cnt;
        at_end    = up ? at_top : at_bottom;
        tc_n      = ~(~carry_en_n & at_end);
    end

endmodule

// File: rtl/udc_stage.sv
module udc_stage
    import udc_pkg::*;
#(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load_n,
    input  logic         up,
    input  logic         cnt_en_n,
    input  logic         carry_en_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] q,
    output logic         tc_n
);

    typedef struct packed {
        logic [W-1:0] cnt;
    } stage_st_t;

    localparam logic [W-1:0] STEP = W'(1);

    stage_st_t st_d;
    stage_st_t st_q;
    op_e       op;

    udc_mode_sel u_mode (
        .rst        (rst),
        .load_n     (load_n),
        .up         (up),
        .cnt_en_n   (cnt_en_n),
        .carry_en_n (carry_en_n),
        .op         (op)
    );

    udc_tc_decode #(.W(W)) u_tc (
        .cnt        (st_q.cnt),
        .up         (up),
        .carry_en_n (carry_en_n),
        .tc_n       (tc_n)
    );

    always_comb begin
        st_d = st_q;
        unique case (op)
            OP_CLEAR: st_d.cnt = '0;
            OP_LOAD:  st_d.cnt = din;
            OP_INC:   st_d.cnt = st_q.cnt + STEP;
            OP_DEC:   st_d.cnt = st_q.cnt - STEP;
            default:  st_d.cnt = st_q.cnt;
        endcase
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign q = st_q.cnt;

    // R1: synchronous clear
    a_r1_clear: assert property (@(posedge clk) rst |=> (q == '0));

    // R2: preset wins over both enables
    a_r2_load: assert property (@(posedge clk) disable iff (rst)
        !load_n |=> (q == $past(din)));

    // R3: either enable inactive keeps the value
    a_r3_hold: assert property (@(posedge clk) disable iff (rst)
        (load_n && (cnt_en_n || carry_en_n)) |=> $stable(q));

    // R4: up step
    a_r4_inc: assert property (@(posedge clk) disable iff (rst)
        (load_n && !cnt_en_n && !carry_en_n && up) |=> (q == $past(q) + STEP));

    // R5: down step
    a_r5_dec: assert property (@(posedge clk) disable iff (rst)
        (load_n && !cnt_en_n && !carry_en_n && !up) |=> (q == $past(q) - STEP));

    // R6: terminal count only with the carry enable active
    a_r6_tc_gated: assert property (@(posedge clk) disable iff (rst)
        !tc_n |-> !carry_en_n);

endmodule

// File: rtl/udc_cascade.sv
module udc_cascade #(
    parameter int STAGE_W = 4,
    parameter int NSTAGE  = 1
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        load_n,
    input  logic                        up,
    input  logic                        cnt_en_n,
    input  logic                        carry_en_n,
    input  logic [STAGE_W*NSTAGE-1:0]   din,
    output logic [STAGE_W*NSTAGE-1:0]   q,
    output logic                        tc_n
);

    localparam int TOT_W = STAGE_W * NSTAGE;

    logic [NSTAGE:0] carry_chain_n;

    assign carry_chain_n[0] = carry_en_n;

    for (genvar k = 0; k < NSTAGE; k++) begin : g_stage
        udc_stage #(.W(STAGE_W)) u_stage (
            .clk        (clk),
            .rst        (rst),
            .load_n     (load_n),
            .up         (up),
            .cnt_en_n   (cnt_en_n),
            .carry_en_n (carry_chain_n[k]),
            .din        (din[STAGE_W*k +: STAGE_W]),
            .q          (q[STAGE_W*k +: STAGE_W]),
            .tc_n       (carry_chain_n[k+1])
        );
    end

    assign tc_n = carry_chain_n[NSTAGE];

    // R7: whole chain wraps upward as one counter
    a_r7_wrap_up: assert property (@(posedge clk) disable iff (rst)
        (load_n && !cnt_en_n && !carry_en_n && up && (q == {TOT_W{1'b1}}))
        |=> (q == '0));

    // R7: whole chain wraps downward as one counter
    a_r7_wrap_down: assert property (@(posedge clk) disable iff (rst)
        (load_n && !cnt_en_n && !carry_en_n && !up && (q == '0))
        |=> (q == {TOT_W{1'b1}}));

    // R6: chain terminal count needs the external carry enable
    a_r6_chain_gated: assert property (@(posedge clk) disable iff (rst)
        !tc_n |-> !carry_en_n);

endmodule

// File: tb/test_udc_cascade.sv
module test_udc_cascade;

    localparam int CLK_PERIOD = 10;
    localparam int SW   = 4;
    localparam int NS   = 3;
    localparam int TW   = SW * NS;
    localparam int MASK = (1 << TW) - 1;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          load_n = 1'b1;
    logic          up = 1'b1;
    logic          cnt_en_n = 1'b1;
    logic          carry_en_n = 1'b1;
    logic [TW-1:0] din = '0;
    logic [TW-1:0] q;
    logic          tc_n;

    logic          s_rst = 1'b1;
    logic          s_load_n = 1'b1;
    logic          s_cnt_en_n = 1'b1;
    logic [SW-1:0] s_din = '0;
    logic [SW-1:0] s_q;
    logic          s_tc_n;

    int checks = 0;
    int errors = 0;
    int ref_cnt = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    udc_cascade #(.STAGE_W(SW), .NSTAGE(NS)) i_udc_cascade (
        .clk(clk), .rst(rst), .load_n(load_n), .up(up),
        .cnt_en_n(cnt_en_n), .carry_en_n(carry_en_n),
        .din(din), .q(q), .tc_n(tc_n)
    );

    udc_cascade #(.STAGE_W(SW), .NSTAGE(1)) i_udc_cascade_one (
        .clk(clk), .rst(s_rst), .load_n(s_load_n), .up(1'b1),
        .cnt_en_n(s_cnt_en_n), .carry_en_n(1'b0),
        .din(s_din), .q(s_q), .tc_n(s_tc_n)
    );

    function automatic int model_next(int cur, bit r, bit ld_n, int d,
                                      bit ce_n, bit ci_n, bit u);
        if (r) return 0;
        if (!ld_n) return d & MASK;
        if (ce_n || ci_n) return cur;
        return u ? ((cur + 1) & MASK) : ((cur - 1) & MASK);
    endfunction

    function automatic bit model_tc_n(int cur, bit ci_n, bit u);
        bit at_end;
        at_end = u ? (cur == MASK) : (cur == 0);
        return !(!ci_n && at_end);
    endfunction

    task automatic check(bit ok, string tag, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Starts and ends at a falling edge. u0 is driven first, u1 just
    // before the rising edge.
    task automatic step(bit r, bit ld_n, int d, bit ce_n, bit ci_n,
                        bit u0, bit u1, string tag);
        rst = r; load_n = ld_n; din = TW'(d); cnt_en_n = ce_n;
        carry_en_n = ci_n; up = u0;
        #1;
        check(tc_n == model_tc_n(ref_cnt, ci_n, u0), {tag, " R6 tc"},
              int'(tc_n), int'(model_tc_n(ref_cnt, ci_n, u0)));
        up = u1;
        #1;
        check(tc_n == model_tc_n(ref_cnt, ci_n, u1), {tag, " R6 tc flip"},
              int'(tc_n), int'(model_tc_n(ref_cnt, ci_n, u1)));
        @(posedge clk);
        ref_cnt = model_next(ref_cnt, r, ld_n, d, ce_n, ci_n, u1);
        @(negedge clk);
        check(int'(q) == ref_cnt, {tag, " q"}, int'(q), ref_cnt);
    endtask

    task automatic s_step(bit r, bit ld_n, int d, bit ce_n,
                          int exp_q, bit exp_tc_n);
        s_rst = r; s_load_n = ld_n; s_din = SW'(d); s_cnt_en_n = ce_n;
        @(posedge clk);
        @(negedge clk);
        check(int'(s_q) == exp_q, "R8 sequence q", int'(s_q), exp_q);
        check(s_tc_n == exp_tc_n, "R8 sequence tc", int'(s_tc_n),
              int'(exp_tc_n));
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        bit r, ldn, cen, cin, u0, u1;
        int d;
        bit dir = 1'b1;
        void'($urandom(32'h1d5a_07c3));
        @(negedge clk);

        // R8: single-stage sequence (tc_n is low while q==15, enables low)
        s_step(1, 1, 0, 1, 0, 1);
        s_step(0, 0, 12, 0, 12, 1);
        s_step(0, 1, 0, 0, 13, 1);
        s_step(0, 1, 0, 0, 14, 1);
        s_step(0, 1, 0, 0, 15, 0);
        s_step(0, 1, 0, 0, 0, 1);
        s_step(0, 1, 0, 0, 1, 1);
        s_step(0, 1, 0, 0, 2, 1);
        s_step(0, 1, 0, 1, 2, 1);
        s_step(0, 1, 0, 1, 2, 1);

        // R1: reset state and reset priority over load and count
        step(1, 1, 0, 1, 1, 1, 1, "R1 reset");
        step(0, 0, 'h5A5, 1, 1, 1, 1, "R2 load");
        step(1, 0, 'h333, 0, 0, 1, 1, "R1 reset over load");
        // R2: load ignores both enables
        step(0, 0, 'h7C1, 0, 0, 0, 0, "R2 load with enables");
        // R3: hold with either enable inactive
        step(0, 1, 0, 1, 0, 1, 1, "R3 hold shared off");
        step(0, 1, 0, 0, 1, 0, 0, "R3 hold carry off");
        // R4/R7: carry across all stages and wrap at 0xFFF
        step(0, 0, 'hFFE, 0, 0, 1, 1, "R2 preset FFE");
        step(0, 1, 0, 0, 0, 1, 1, "R4 up to FFF");
        step(0, 1, 0, 0, 0, 1, 1, "R7 wrap FFF to 000");
        // R5/R7: borrow across all stages and wrap at 0x000
        step(0, 1, 0, 0, 0, 0, 0, "R7 wrap 000 to FFF");
        step(0, 1, 0, 0, 0, 0, 0, "R5 down FFE");
        step(0, 0, 'h100, 0, 0, 0, 0, "R2 preset 100");
        step(0, 1, 0, 0, 0, 0, 0, "R5 borrow to 0FF");
        // R9: direction flipped inside a cycle, edge value rules
        step(0, 1, 0, 0, 0, 0, 1, "R9 flip to up");
        step(0, 1, 0, 0, 0, 1, 0, "R9 flip to down");
        // R6: terminal count with carry inactive at the end value
        step(0, 0, 'h000, 1, 1, 0, 0, "R2 preset 000");
        step(0, 1, 0, 1, 1, 0, 0, "R6 carry off at zero");

        // Random mix around both wrap points
        for (int i = 0; i < 3000; i++) begin
            if ($urandom_range(19) == 0) dir = ~dir;
            r   = ($urandom_range(127) == 0);
            ldn = ($urandom_range(15) != 0);
            cen = ($urandom_range(9) < 2);
            cin = ($urandom_range(9) < 1);
            u0  = $urandom_range(1);
            u1  = dir;
            case ($urandom_range(3))
                0: d = 'hFFD + $urandom_range(2);
                1: d = $urandom_range(2);
                default: d = $urandom_range(MASK);
            endcase
            step(r, ldn, d, cen, cin, u0, u1, "R7 random");
        end

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule